// File: doc/BRIEF.md
# Banked Multi-Port Match Hash Table

This block is the candidate-finding stage of a dictionary (LZ-style) compressor. Each clock it takes a beat of four consecutive stream positions together with the seven bytes that cover their four-byte windows. For every position it hashes the window, reads the table entry under that hash to get an earlier position that may start a match, and then writes the current position into the same entry so that later windows can find it. A downstream stage uses the candidates to check match length; this block only proposes them.

The table is split into many small banks. Each bank performs one read and one write per cycle. A lane's hash chooses its bank and the entry in that bank. When two lanes of a beat land in the same bank, the lower-numbered lane is served and the others are dropped. The pipeline never stalls, so a conflict only costs a little match quality. A block-start strobe starts a new compression block in a single cycle: it advances a generation tag, and entries carrying an older tag read as empty.

Top module: `matchHashTable`

## Requirements
- R1: A beat is accepted every cycle with no back-pressure. Lane l (0..3) holds position basePos+l (modulo 2^16). Its window word is inBytes[8*l+31 : 8*l], so byte l of inBytes is the word's least significant byte.
- R2: The hash of a window word w is bits 31..22 of (w * 0x9E3779B1) mod 2^32. Hash bits 5..0 select one of 64 banks, and hash bits 9..6 select one of 16 entries in that bank.
- R3: A served lookup whose entry was last written in the current block raises the lane's candidate flag. The candidate position is the position stored by that most recent write.
- R4: A lookup whose entry has not been written since the current block began returns a candidate flag of 0.
- R5: A lookup sees the table as it was before the updates of its own beat, so no candidate is forwarded between lanes of one beat. An update made by one beat is visible to the beat in the very next cycle.
- R6: Among the valid lanes of a beat that target the same bank, only the lowest-numbered lane is served. Every other lane in that bank returns a candidate flag of 0, and its update is discarded, so its entry keeps its earlier content.
- R7: When blockStart is high in a cycle, the beat presented in that cycle and every later beat see none of the entries written before it. This takes effect with no dead cycles, and blockStart counts even when inValid is low.
- R8: Results of a beat presented in cycle c appear on candValid/candPos in cycle c+2. A cycle with inValid low produces all-zero candidate flags two cycles later and changes no entry.
- R9: While rstN is low and just after it is released, every candidate flag is 0 and the table holds no valid entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | The beat on basePos/inBytes is valid |
| blockStart | input | 1 | Begin a new compression block with this cycle |
| basePos | input | 16 | Stream position of lane 0 |
| inBytes | input | 56 | Seven stream bytes starting at basePos, byte 0 in bits 7..0 |
| candValid | output | 4 | Per-lane candidate found flag |
| candPos | output | 64 | Per-lane candidate position, lane l in bits 16*l+15 : 16*l |

## Verification
Every beat, whether valid or idle, yields its results exactly two cycles after the cycle in which it is driven. The bench drives beats at the falling edge and stamps each expected result with a due cycle two rising edges later. The monitor compares only the queue head whose due cycle matches, sampling at the falling edge. The expected table contents come from a bench model of the hash, the lowest-lane arbitration and the block counter. This model is updated in read-then-write order for each beat, so visibility in the next cycle and dropped updates are checked against the cycle in which they become observable.

// File: rtl/mhtPkg.sv
package mhtPkg;
  localparam int LANES     = 4;
  localparam int WIN_BYTES = 4;
  localparam int BANK_BITS = 6;
  localparam int IDX_BITS  = 4;
  localparam int POS_W     = 16;
  localparam int GEN_W     = 8;

  localparam int BANKS     = 1 << BANK_BITS;
  localparam int ENTRIES   = 1 << IDX_BITS;
  localparam int HASH_BITS = BANK_BITS + IDX_BITS;
  localparam int WORD_W    = 8 * WIN_BYTES;
  localparam int STREAM_W  = 8 * (LANES + WIN_BYTES - 1);

  localparam logic [WORD_W-1:0] HASH_MUL = 32'h9E3779B1;

  // Strobes from control to datapath
  typedef struct packed {
    logic [LANES-1:0] grant;    // lane served by its bank this cycle
    logic [GEN_W-1:0] beatGen;  // generation tag for the beat being accepted
  } strobe_t;

  function automatic logic [HASH_BITS-1:0] hashWindow(input logic [WORD_W-1:0] word);
    logic [WORD_W-1:0] prod;
    prod = word * HASH_MUL;
    return prod[WORD_W-1 -: HASH_BITS];
  endfunction
endpackage

// File: rtl/mhtBank.sv
module mhtBank
  import mhtPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [IDX_BITS-1:0] entryIdx,
  input  logic                wrEn,
  input  logic [POS_W-1:0]    wrPos,
  input  logic [GEN_W-1:0]    wrGen,
  output logic                rdValid,
  output logic [POS_W-1:0]    rdPos,
  output logic [GEN_W-1:0]    rdGen
);
  logic [ENTRIES-1:0] validBits;
  logic [POS_W-1:0]   posMem [ENTRIES];
  logic [GEN_W-1:0]   genMem [ENTRIES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     validBits <= '0;
    else if (wrEn) validBits[entryIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wrEn) begin
      posMem[entryIdx] <= wrPos;
      genMem[entryIdx] <= wrGen;
    end
  end

  // read returns contents from before this edge's write
  assign rdValid = validBits[entryIdx];
  assign rdPos   = posMem[entryIdx];
  assign rdGen   = genMem[entryIdx];
endmodule

// File: rtl/mhtCtrl.sv
module mhtCtrl
  import mhtPkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              blockStart,
  input  logic                              s1Valid,
  input  logic [LANES-1:0][BANK_BITS-1:0]   s1Bank,
  output strobe_t                           strobes
);
  logic [GEN_W-1:0] curGen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           curGen <= '0;
    else if (blockStart) curGen <= curGen + 1'b1;
  end

  always_comb begin
    strobes.beatGen = blockStart ? curGen + 1'b1 : curGen;
    for (int l = 0; l < LANES; l++) begin
      strobes.grant[l] = s1Valid;
      for (int j = 0; j < l; j++) begin
        if (s1Bank[j] == s1Bank[l]) strobes.grant[l] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/mhtDatapath.sv
module mhtDatapath
  import mhtPkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            inValid,
  input  logic [POS_W-1:0]                basePos,
  input  logic [STREAM_W-1:0]             inBytes,
  input  strobe_t                         strobes,
  output logic                            s1Valid,
  output logic [LANES-1:0][BANK_BITS-1:0] s1Bank,
  output logic [LANES-1:0]                candValid,
  output logic [LANES-1:0][POS_W-1:0]     candPos
);
  logic [LANES-1:0][HASH_BITS-1:0] inHash;
  logic [LANES-1:0][HASH_BITS-1:0] s1Hash;
  logic [LANES-1:0][POS_W-1:0]     s1Pos;
  logic [LANES-1:0][IDX_BITS-1:0]  s1Idx;
  logic [GEN_W-1:0]                s1Gen;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      inHash[l] = hashWindow(inBytes[8*l +: WORD_W]);
    end
  end

  // Stage 1: hashes, positions, generation tag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Hash  <= '0;
      s1Pos   <= '0;
      s1Gen   <= '0;
    end else begin
      s1Valid <= inValid;
      s1Hash  <= inHash;
      s1Gen   <= strobes.beatGen;
      for (int l = 0; l < LANES; l++) begin
        s1Pos[l] <= basePos + POS_W'(l);
      end
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      s1Bank[l] = s1Hash[l][BANK_BITS-1:0];
      s1Idx[l]  = s1Hash[l][HASH_BITS-1:BANK_BITS];
    end
  end

  logic [BANKS-1:0] bankRdValid;
  logic [POS_W-1:0] bankRdPos [BANKS];
  logic [GEN_W-1:0] bankRdGen [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam logic [BANK_BITS-1:0] BANK_ID = BANK_BITS'(b);
    logic                bankWr;
    logic [IDX_BITS-1:0] bankIdx;
    logic [POS_W-1:0]    bankPos;

    // at most one granted lane per bank
    always_comb begin
      bankWr  = 1'b0;
      bankIdx = '0;
      bankPos = '0;
      for (int l = 0; l < LANES; l++) begin
        if (strobes.grant[l] && (s1Bank[l] == BANK_ID)) begin
          bankWr  = 1'b1;
          bankIdx = s1Idx[l];
          bankPos = s1Pos[l];
        end
      end
    end

    mhtBank u_bank (
      .clk     (clk),
      .rstN    (rstN),
      .entryIdx(bankIdx),
      .wrEn    (bankWr),
      .wrPos   (bankPos),
      .wrGen   (s1Gen),
      .rdValid (bankRdValid[b]),
      .rdPos   (bankRdPos[b]),
      .rdGen   (bankRdGen[b])
    );
  end

  // Stage 2: candidate registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candValid <= '0;
      candPos   <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        candValid[l] <= strobes.grant[l] && bankRdValid[s1Bank[l]] &&
                        (bankRdGen[s1Bank[l]] == s1Gen);
        candPos[l]   <= bankRdPos[s1Bank[l]];
      end
    end
  end
endmodule

// File: rtl/matchHashTable.sv
module matchHashTable
  import mhtPkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic                   blockStart,
  input  logic [POS_W-1:0]       basePos,
  input  logic [STREAM_W-1:0]    inBytes,
  output logic [LANES-1:0]       candValid,
  output logic [LANES*POS_W-1:0] candPos
);
  strobe_t                         strobes;
  logic                            s1Valid;
  logic [LANES-1:0][BANK_BITS-1:0] s1Bank;
  logic [LANES-1:0][POS_W-1:0]     candPosLanes;

  mhtCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .blockStart(blockStart),
    .s1Valid   (s1Valid),
    .s1Bank    (s1Bank),
    .strobes   (strobes)
  );

  mhtDatapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .basePos  (basePos),
    .inBytes  (inBytes),
    .strobes  (strobes),
    .s1Valid  (s1Valid),
    .s1Bank   (s1Bank),
    .candValid(candValid),
    .candPos  (candPosLanes)
  );

  assign candPos = candPosLanes;
endmodule

// File: rtl/mhtChecker.sv
module mhtChecker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        blockStart,
  input logic [39:0] winBytes,
  input logic [3:0]  candValid
);
  // R8: an idle beat gives no candidates two cycles later
  assert_idle_silent_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inValid, 2) |-> (candValid == 4'b0));

  // R7: the beat carrying blockStart sees an empty table
  assert_fresh_block_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(blockStart, 2) |-> (candValid == 4'b0));

  // R6: lane 1 with the same window as lane 0 loses its bank
  assert_same_window_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && (winBytes[31:0] == winBytes[39:8]), 2) |-> !candValid[1]);

  // R9: flags are clear as reset is released
  assert_reset_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (candValid == 4'b0));
endmodule

bind matchHashTable mhtChecker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .blockStart(blockStart),
  .winBytes  (inBytes[39:0]),
  .candValid (candValid)
);

// File: tb/tb_matchHashTable.sv
module tb_matchHashTable;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        blockStart = 1'b0;
  logic [15:0] basePos = '0;
  logic [55:0] inBytes = '0;
  logic [3:0]  candValid;
  logic [63:0] candPos;

  matchHashTable dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .blockStart(blockStart),
    .basePos(basePos), .inBytes(inBytes), .candValid(candValid), .candPos(candPos)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          due;
    logic [3:0]  v;
    logic [63:0] p;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  int   cycleCount = 0;
  int   checks = 0;
  int   failures = 0;
  int   blkId = 0;
  bit          mValid [1024];
  int          mBlk   [1024];
  logic [15:0] mPos   [1024];

  always @(posedge clk) cycleCount <= cycleCount + 1;

  // hash from R2
  function automatic logic [9:0] refHash(input logic [31:0] w);
    logic [31:0] prod;
    prod = w * 32'h9E3779B1;
    return prod[31:22];
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // driver: applies one beat and pushes its expected result
  task automatic driveBeat(input bit v, input bit bs, input logic [15:0] base,
                           input logic [55:0] bytes, input string tag);
    exp_t item;
    logic [9:0] hs [4];
    bit g [4];
    @(negedge clk);
    inValid = v; blockStart = bs; basePos = base; inBytes = bytes;
    if (bs) blkId++;
    item.due = cycleCount + 2;
    item.v = '0;
    item.p = '0;
    item.tag = tag;
    if (v) begin
      for (int l = 0; l < 4; l++) hs[l] = refHash(bytes[8*l +: 32]);
      for (int l = 0; l < 4; l++) begin
        g[l] = 1'b1;
        for (int j = 0; j < l; j++) if (hs[j][5:0] == hs[l][5:0]) g[l] = 1'b0;
      end
      for (int l = 0; l < 4; l++) begin
        if (g[l] && mValid[hs[l]] && mBlk[hs[l]] == blkId) begin
          item.v[l] = 1'b1;
          item.p[16*l +: 16] = mPos[hs[l]];
        end
      end
      for (int l = 0; l < 4; l++) begin
        if (g[l]) begin
          mValid[hs[l]] = 1'b1;
          mBlk[hs[l]]   = blkId;
          mPos[hs[l]]   = base + 16'(l);
        end
      end
    end
    expQ.push_back(item);
  endtask

  // monitor: compares results on their due cycle
  always @(negedge clk) begin
    if (rstN && expQ.size() > 0 && expQ[0].due == cycleCount) begin
      exp_t item;
      item = expQ.pop_front();
      for (int l = 0; l < 4; l++) begin
        check(candValid[l] == item.v[l], item.tag, $sformatf("lane%0d flag", l),
              int'(candValid[l]), int'(item.v[l]));
        if (item.v[l])
          check(candPos[16*l +: 16] == item.p[16*l +: 16], item.tag,
                $sformatf("lane%0d pos", l),
                int'(candPos[16*l +: 16]), int'(item.p[16*l +: 16]));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    logic [55:0] pat;
    logic [55:0] cpat;
    logic [15:0] pos;
    bit found;
    logic [7:0] fb0, fb4;

    for (int i = 0; i < 1024; i++) begin mValid[i] = 1'b0; mBlk[i] = 0; mPos[i] = '0; end

    repeat (3) @(posedge clk);
    check(candValid == 4'b0, "R9", "flags in reset", int'(candValid), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(candValid == 4'b0, "R9", "flags after reset", int'(candValid), 0);

    // R4 empty table, then R5 next-cycle visibility, R3 overwrite
    pat = 56'h7766_5544_3322_11;
    driveBeat(1, 0, 16'd0,   pat, "R4 empty table");
    driveBeat(1, 0, 16'd100, pat, "R5 next beat sees update");
    driveBeat(1, 0, 16'd200, pat, "R3 latest position");
    driveBeat(0, 0, 16'd0,   pat, "R8 idle beat");
    driveBeat(0, 0, 16'd0,   pat, "R8 idle beat");
    driveBeat(1, 0, 16'd300, pat, "R8 idle left table intact");

    // R6 identical windows in all lanes: only lane 0 served
    driveBeat(1, 0, 16'd400, {7{8'h41}}, "R6 same window all lanes");
    driveBeat(1, 0, 16'd410, {7{8'h41}}, "R6 lane0 hit only");

    // R7 block start: carrying beat and followers see nothing old
    driveBeat(1, 1, 16'd500, pat, "R7 start beat misses");
    driveBeat(1, 0, 16'd504, pat, "R7 new block hits");
    driveBeat(0, 1, 16'd0,   pat, "R7 start while idle");
    driveBeat(1, 0, 16'd600, pat, "R7 idle start cleared");

    // R6 discarded update: lane 1 shares lane 0's bank, different entry
    found = 0;
    fb0 = 8'h00; fb4 = 8'h00;
    for (int b0 = 0; b0 < 256 && !found; b0++) begin
      for (int b4 = 0; b4 < 256 && !found; b4++) begin
        logic [9:0] h1, h2;
        h1 = refHash({8'h33, 8'h22, 8'h11, 8'(b0)});
        h2 = refHash({8'(b4), 8'h33, 8'h22, 8'h11});
        if (h1[5:0] == h2[5:0] && h1[9:6] != h2[9:6]) begin
          found = 1; fb0 = 8'(b0); fb4 = 8'(b4);
        end
      end
    end
    check(found, "R2", "bank-sharing pair", int'(found), 1);
    cpat = {8'h5A, 8'hA5, fb4, 8'h33, 8'h22, 8'h11, fb0};
    driveBeat(1, 1, 16'd700, cpat, "R6 bank conflict beat");
    driveBeat(1, 0, 16'd710, {8'hC3, 8'h3C, 8'h96, fb4, 8'h33, 8'h22, 8'h11},
              "R6 loser update dropped");
    driveBeat(1, 0, 16'd720, {8'h69, 8'hF0, 8'h0F, 8'h33, 8'h22, 8'h11, fb0},
              "R6 winner update kept");

    // R1 R2 random traffic over a small alphabet
    pos = 16'd1000;
    for (int n = 0; n < 400; n++) begin
      logic [55:0] rb;
      for (int k = 0; k < 7; k++) rb[8*k +: 8] = ($urandom % 3 == 0) ? 8'h42 : 8'h41;
      driveBeat(($urandom % 8) != 0, (n % 60) == 59, pos, rb, "R1 R2 random");
      pos = pos + 16'd4;
    end

    for (int n = 0; n < 4; n++) driveBeat(0, 0, 16'd0, '0, "R8 drain");
    while (expQ.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule